// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block sequences the program counter for an in-order pipeline whose instruction set defines one branch delay slot. It keeps two address registers: the address of the instruction now in decode and the address now being fetched. With no control transfer, the fetch address steps forward by one instruction word each cycle. When decode reports a branch, its condition is already resolved, so the branch only changes the fetch address for the next cycle. The instruction fetched while the branch sits in decode is the delay-slot instruction, and it is always issued.

The block also tags that delay-slot instruction with a squash flag. The flag is raised in the cycle the slot instruction reaches decode, and the per-branch annul mode decides when it is raised: never, only when the branch falls through, or only when the branch is taken. A squashed instruction has no architectural effect. If it decodes as a branch, the sequencer ignores it. A stall freezes the whole sequencer.

Top module: `dslot_fetch_seq`

## Requirements
- R1: While reset is asserted, the fetch address equals RESET_VEC, the decode address equals RESET_VEC minus one instruction word, and the squash flag is 0.
- R2: On an unstalled cycle with no redirecting branch, the fetch address advances by INSN_BYTES and wraps modulo 2^AW.
- R3: On every unstalled cycle, the decode address takes the previous fetch address. As a result, the instruction after a branch (the delay slot) is always fetched and issued.
- R4: An unstalled cycle with a valid, taken branch in a slot that is not squashed makes the next fetch address equal to the branch target.
- R5: A valid branch that is not taken leaves the fetch address on its sequential path.
- R6: Annul mode 2'b00 never raises the squash flag.
- R7: Annul mode 2'b01 raises the squash flag in the cycle after a valid branch that is not taken, and not after a taken one.
- R8: Annul mode 2'b10 raises the squash flag in the cycle after a valid taken branch, and not after a not-taken one.
- R9: Annul mode 2'b11 behaves as 2'b00.
- R10: While the squash flag is high, the branch inputs are ignored. The next fetch address is sequential and the squash flag falls after that cycle.
- R11: While stall is high, the fetch address, the decode address and the squash flag all hold, and the branch inputs have no effect.
- R12: With ALIGN_TARGET set, the low log2(INSN_BYTES) bits of a branch target are cleared before it is used.
- R13: The taken flag and the annul mode have no effect while the branch-valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freezes the sequencer for the cycle |
| br_valid_i | input | 1 | Decode holds a branch this cycle |
| br_taken_i | input | 1 | Resolved branch condition |
| br_target_i | input | AW | Branch target address |
| annul_mode_i | input | 2 | Delay-slot annul policy for this branch |
| fetch_pc_o | output | AW | Address fetched this cycle |
| dec_pc_o | output | AW | Address of the instruction now in decode |
| slot_squash_o | output | 1 | The instruction in decode is an annulled delay slot |

## Verification
The bench builds the block with AW = 16, RESET_VEC = 16'h0040 and the default four-byte word with target alignment on. The narrow address lets a branch to 16'hFFF8 followed by two sequential steps reach the wrap to zero. An unaligned target (16'h0803) exercises the alignment path. The vector sequence chains back-to-back branches, branches placed in squashed slots and stalls over a raised squash flag. This covers the annul decision under each of the four mode codes.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

   typedef enum logic [1:0] {
      SLOT_KEEP      = 2'b00,
      SLOT_KILL_NT   = 2'b01,
      SLOT_KILL_T    = 2'b10,
      SLOT_RSVD      = 2'b11
   } slot_mode_e;

   // Decision for the delay slot that follows a branch which fires.
   function automatic logic slot_kill(input slot_mode_e mode, input logic taken);
      logic kill;
      unique case (mode)
         SLOT_KILL_NT: kill = ~taken;
         SLOT_KILL_T:  kill = taken;
         default:      kill = 1'b0;
      endcase
      return kill;
   endfunction

endpackage

// File: rtl/dslot_step_adder.sv
module dslot_step_adder #(
   parameter int unsigned AW   = 32,
   parameter int unsigned STEP = 4
) (
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o
);
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   if (STEP == 0) begin : g_bad_step
      $error("dslot_step_adder: STEP must be non-zero");
   end

   assign addr_o = addr_i + STEP_V;
endmodule

// File: rtl/dslot_target_align.sv
module dslot_target_align #(
   parameter int unsigned AW           = 32,
   parameter int unsigned INSN_BYTES   = 4,
   parameter bit          ALIGN_TARGET = 1'b1
) (
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] target_o
);
   localparam logic [AW-1:0] LOW_MASK = AW'(INSN_BYTES) - AW'(1);

   if (ALIGN_TARGET && INSN_BYTES > 1) begin : g_align
      assign target_o = target_i & ~LOW_MASK;
   end else begin : g_pass
      assign target_o = target_i;
   end
endmodule

// File: rtl/dslot_annul_policy.sv
module dslot_annul_policy
   import dslot_pkg::*;
(
   input  logic       fire_i,
   input  logic       taken_i,
   input  logic [1:0] mode_i,
   output logic       kill_o
);
   slot_mode_e mode;

   always_comb begin
      mode   = slot_mode_e'(mode_i);
      kill_o = fire_i & slot_kill(mode, taken_i);
   end
endmodule

// File: rtl/dslot_pc_regs.sv
module dslot_pc_regs #(
   parameter int unsigned   AW         = 32,
   parameter int unsigned   INSN_BYTES = 4,
   parameter logic [AW-1:0] RESET_VEC  = '0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          hold_i,
   input  logic [AW-1:0] npc_nxt_i,
   input  logic          kill_nxt_i,
   output logic [AW-1:0] pc_o,
   output logic [AW-1:0] npc_o,
   output logic          kill_o
);
   localparam logic [AW-1:0] PC_RST = RESET_VEC - AW'(INSN_BYTES);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc_o   <= PC_RST;
         npc_o  <= RESET_VEC;
         kill_o <= 1'b0;
      end else if (!hold_i) begin
         pc_o   <= npc_o;
         npc_o  <= npc_nxt_i;
         kill_o <= kill_nxt_i;
      end
   end
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq #(
   parameter int unsigned   AW           = 32,
   parameter int unsigned   INSN_BYTES   = 4,
   parameter bit            ALIGN_TARGET = 1'b1,
   parameter logic [AW-1:0] RESET_VEC    = AW'(32'h0000_1000)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          stall_i,
   input  logic          br_valid_i,
   input  logic          br_taken_i,
   input  logic [AW-1:0] br_target_i,
   input  logic [1:0]    annul_mode_i,
   output logic [AW-1:0] fetch_pc_o,
   output logic [AW-1:0] dec_pc_o,
   output logic          slot_squash_o
);
   localparam logic [AW-1:0] LOW_MASK = AW'(INSN_BYTES) - AW'(1);

   // Elaboration-time parameter checks
   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("dslot_fetch_seq: AW must lie in 8..64");
   end
   if (INSN_BYTES == 0 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_word
      $error("dslot_fetch_seq: INSN_BYTES must be a power of two");
   end
   if ((RESET_VEC & LOW_MASK) != '0) begin : g_bad_vec
      $error("dslot_fetch_seq: RESET_VEC must be word aligned");
   end

   logic [AW-1:0] pc_q, npc_q, seq_pc, tgt_al, npc_nxt;
   logic          kill_q, fire, redirect, kill_nxt;

   // A branch decoded inside an annulled slot is dead.
   assign fire     = br_valid_i & ~kill_q;
   assign redirect = fire & br_taken_i;

   dslot_step_adder #(.AW(AW), .STEP(INSN_BYTES)) u_step (
      .addr_i (npc_q),
      .addr_o (seq_pc)
   );

   dslot_target_align #(
      .AW(AW), .INSN_BYTES(INSN_BYTES), .ALIGN_TARGET(ALIGN_TARGET)
   ) u_align (
      .target_i (br_target_i),
      .target_o (tgt_al)
   );

   dslot_annul_policy u_policy (
      .fire_i  (fire),
      .taken_i (br_taken_i),
      .mode_i  (annul_mode_i),
      .kill_o  (kill_nxt)
   );

   assign npc_nxt = redirect ? tgt_al : seq_pc;

   dslot_pc_regs #(
      .AW(AW), .INSN_BYTES(INSN_BYTES), .RESET_VEC(RESET_VEC)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hold_i     (stall_i),
      .npc_nxt_i  (npc_nxt),
      .kill_nxt_i (kill_nxt),
      .pc_o       (pc_q),
      .npc_o      (npc_q),
      .kill_o     (kill_q)
   );

   assign fetch_pc_o    = npc_q;
   assign dec_pc_o      = pc_q;
   assign slot_squash_o = kill_q;
endmodule

// File: rtl/dslot_fetch_seq_chk.sv
module dslot_fetch_seq_chk #(
   parameter int unsigned AW           = 32,
   parameter int unsigned INSN_BYTES   = 4,
   parameter bit          ALIGN_TARGET = 1'b1
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          stall_i,
   input logic          br_valid_i,
   input logic          br_taken_i,
   input logic [AW-1:0] br_target_i,
   input logic [1:0]    annul_mode_i,
   input logic [AW-1:0] fetch_pc_o,
   input logic [AW-1:0] dec_pc_o,
   input logic          slot_squash_o
);
   localparam logic [AW-1:0] STEP_V = AW'(INSN_BYTES);
   localparam logic [AW-1:0] KEEP_M = (ALIGN_TARGET && INSN_BYTES > 1) ?
                                      ~(STEP_V - AW'(1)) : '1;

   p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && !(br_valid_i && br_taken_i && !slot_squash_o))
      |=> fetch_pc_o == $past(fetch_pc_o) + STEP_V);

   p_slot_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stall_i |=> dec_pc_o == $past(fetch_pc_o));

   p_redirect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && br_valid_i && br_taken_i && !slot_squash_o)
      |=> fetch_pc_o == ($past(br_target_i) & KEEP_M));

   p_keep_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && annul_mode_i == 2'b00) |=> !slot_squash_o);

   p_dead_branch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && slot_squash_o) |=> !slot_squash_o);

   p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_i |=> ($stable(fetch_pc_o) && $stable(dec_pc_o) && $stable(slot_squash_o)));

   p_no_valid_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stall_i && !br_valid_i) |=> !slot_squash_o);
endmodule

bind dslot_fetch_seq dslot_fetch_seq_chk #(
   .AW(AW), .INSN_BYTES(INSN_BYTES), .ALIGN_TARGET(ALIGN_TARGET)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .stall_i       (stall_i),
   .br_valid_i    (br_valid_i),
   .br_taken_i    (br_taken_i),
   .br_target_i   (br_target_i),
   .annul_mode_i  (annul_mode_i),
   .fetch_pc_o    (fetch_pc_o),
   .dec_pc_o      (dec_pc_o),
   .slot_squash_o (slot_squash_o)
);

// File: tb/tb_dslot_fetch_seq.sv
module tb_dslot_fetch_seq;
   localparam int unsigned AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall = 1'b0, bv = 1'b0, bt = 1'b0;
   logic [AW-1:0] tgt = '0;
   logic [1:0]    mode = 2'b00;
   logic [AW-1:0] fetch_pc, dec_pc;
   logic          squash;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dslot_fetch_seq #(
      .AW(AW), .INSN_BYTES(4), .ALIGN_TARGET(1'b1), .RESET_VEC(16'h0040)
   ) dut (
      .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .br_valid_i(bv),
      .br_taken_i(bt), .br_target_i(tgt), .annul_mode_i(mode),
      .fetch_pc_o(fetch_pc), .dec_pc_o(dec_pc), .slot_squash_o(squash)
   );

   typedef struct packed {
      logic          st, v, t;
      logic [1:0]    md;
      logic [AW-1:0] tg, ef, ed;
      logic          es;
      logic [3:0]    req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0044,16'h0040,1'b0,4'd2},  // R2
      '{1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0048,16'h0044,1'b0,4'd3},  // R3
      '{1'b0,1'b1,1'b1,2'b00,16'h0200,16'h0200,16'h0048,1'b0,4'd4},  // R4 slot 0048 issues
      '{1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0204,16'h0200,1'b0,4'd2},  // R2
      '{1'b0,1'b1,1'b1,2'b01,16'h0300,16'h0300,16'h0204,1'b0,4'd7},  // R7 taken: keep
      '{1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0304,16'h0300,1'b0,4'd2},  // R2
      '{1'b0,1'b1,1'b0,2'b01,16'h0500,16'h0308,16'h0304,1'b1,4'd7},  // R7 / R5
      '{1'b0,1'b1,1'b1,2'b00,16'h0700,16'h030C,16'h0308,1'b0,4'd10}, // R10 dead branch
      '{1'b0,1'b1,1'b1,2'b10,16'h0803,16'h0800,16'h030C,1'b1,4'd12}, // R12 / R8
      '{1'b0,1'b1,1'b1,2'b10,16'h0900,16'h0804,16'h0800,1'b0,4'd10}, // R10
      '{1'b1,1'b1,1'b1,2'b10,16'h0A00,16'h0804,16'h0800,1'b0,4'd11}, // R11
      '{1'b0,1'b1,1'b0,2'b10,16'h0B00,16'h0808,16'h0804,1'b0,4'd8},  // R8 not taken
      '{1'b0,1'b1,1'b1,2'b11,16'h0C00,16'h0C00,16'h0808,1'b0,4'd9},  // R9
      '{1'b0,1'b0,1'b1,2'b01,16'h0D00,16'h0C04,16'h0C00,1'b0,4'd13}, // R13
      '{1'b0,1'b1,1'b0,2'b11,16'h0E00,16'h0C08,16'h0C04,1'b0,4'd9},  // R9
      '{1'b0,1'b1,1'b0,2'b01,16'h0F00,16'h0C0C,16'h0C08,1'b1,4'd7},  // R7
      '{1'b1,1'b0,1'b0,2'b00,16'h0000,16'h0C0C,16'h0C08,1'b1,4'd11}, // R11 flag held
      '{1'b0,1'b0,1'b0,2'b00,16'h0000,16'h0C10,16'h0C0C,1'b0,4'd10}, // R10
      '{1'b0,1'b1,1'b1,2'b00,16'h1000,16'h1000,16'h0C10,1'b0,4'd6},  // R6
      '{1'b0,1'b1,1'b1,2'b00,16'h2000,16'h2000,16'h1000,1'b0,4'd4}   // R4 branch in live slot
   };

   task automatic check(input string req, input logic [AW-1:0] ef, ed, input logic es);
      n_chk++;
      if (fetch_pc !== ef || dec_pc !== ed || squash !== es) begin
         n_bad++;
         $display("FAIL %s: fetch=%h dec=%h squash=%b expected fetch=%h dec=%h squash=%b",
                  req, fetch_pc, dec_pc, squash, ef, ed, es);
      end
   endtask

   task automatic drive(input logic s, v, t, input logic [1:0] m, input logic [AW-1:0] g);
      stall = s; bv = v; bt = t; mode = m; tgt = g;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 16'h0040, 16'h003C, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].st, VECS[i].v, VECS[i].t, VECS[i].md, VECS[i].tg);
         @(negedge clk);
         check($sformatf("R%0d", VECS[i].req), VECS[i].ef, VECS[i].ed, VECS[i].es);
      end
      // R2 wrap of the sequential path
      drive(1'b0, 1'b1, 1'b1, 2'b00, 16'hFFF8);
      @(negedge clk);
      check("R4", 16'hFFF8, 16'h2000, 1'b0);
      drive(1'b0, 1'b0, 1'b0, 2'b00, 16'h0000);
      @(negedge clk);
      check("R2", 16'hFFFC, 16'hFFF8, 1'b0);
      @(negedge clk);
      check("R2", 16'h0000, 16'hFFFC, 1'b0);
      // R1 reset in mid-run over a pending squash
      drive(1'b0, 1'b1, 1'b0, 2'b01, 16'h0000);
      @(negedge clk);
      check("R7", 16'h0004, 16'h0000, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R1", 16'h0040, 16'h003C, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b0, 2'b00, 16'h0000);
      @(negedge clk);
      check("R2", 16'h0044, 16'h0040, 1'b0);
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule